// File: doc/BRIEF.md
# Flash Query-Table Read Responder

This block is the command front end of a parallel NOR flash that can answer a standard parameter query. It watches write cycles on the host bus for a small set of command bytes and keeps a three-state mode register: array read, autoselect, or query. In array-read mode, reads pass the array data input through to the read-data output. In query mode, reads return entries from a fixed parameter table. The table holds an identification string, command-set and extended-table pointers, and system-interface values such as voltage limits and log2-coded timeouts.

The host reads the table in word (x16) or byte (x8) bus mode. In byte mode every entry sits at twice its word offset, so the host address carries one extra low bit. Command addresses are also compared as word addresses, which puts the command location at byte address AAh in x8 mode. The read-data output is registered: it updates on the clock edge where the read strobe is sampled high and otherwise holds its value.

Top module: `qry_resp`

## Requirements
- R1: A synchronous reset puts the block in array-read mode and clears rdata to 0. After reset, a read returns array_data unchanged.
- R2: In array-read mode, a write of data 98h to word address 55h while ready=1 enters query mode.
- R3: A query command (98h to word address 55h) written while ready=0 is ignored, and reads keep returning array_data.
- R4: A write of 90h to word address 55h in array-read mode enters autoselect mode. There, word offset 0 reads 0001h and every other offset reads 0.
- R5: A query command written in autoselect mode moves the block into query mode.
- R6: Query mode lasts over any number of reads. A write whose low data byte is F0h returns the block to array-read mode from any mode.
- R7: In x16 query mode, word offsets 10h, 11h and 12h read 0051h, 0052h and 0059h, and the upper data byte of every table read is 0.
- R8: In x16 query mode, offset 13h reads 0002h, offset 15h reads 0040h, and offsets 14h and 16h to 1Ah read 0.
- R9: In x16 query mode, offsets 1Bh to 26h read 27h, 36h, 00h, 00h, 07h, 07h, 0Ah, 00h, 03h, 05h, 04h and 00h in that order.
- R10: With byte_mode=1, byte address 2*N returns table entry N, and odd byte addresses return 0.
- R11: In query mode, word offsets below 10h or above 26h read 0.
- R12: rdata changes only on the clock edge where rd_en is sampled high, and it holds while rd_en is low.
- R13: In query mode, a write whose low data byte is not F0h leaves the block in query mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, sampled on the clock edge |
| rd_en | input | 1 | Read strobe, sampled on the clock edge |
| byte_mode | input | 1 | 1 selects x8 addressing, 0 selects x16 |
| ready | input | 1 | Array ready flag, 0 while busy |
| addr | input | ADDR_W (8) | Bus address (word or byte) |
| wdata | input | DATA_W (16) | Write data, command in the low byte |
| array_data | input | DATA_W (16) | Data from the memory array |
| rdata | output | DATA_W (16) | Registered read data |

## Verification
A command write takes effect on the clock edge that samples wr_en, so a read issued in the next cycle already sees the new mode. A read result appears in rdata one edge after rd_en is sampled. The bench drives both strobes at the falling edge. The scoreboard takes one expected word per read and pops it at the falling edge that follows the sampling rising edge. The hold behaviour is checked directly one idle cycle after a read, with array_data changed in between.

// File: rtl/qry_pkg.sv
package qry_pkg;

    typedef enum logic [1:0] {
        MD_ARRAY   = 2'd0,
        MD_AUTOSEL = 2'd1,
        MD_QUERY   = 2'd2
    } mode_e;

    localparam logic [7:0] CMD_QUERY   = 8'h98;
    localparam logic [7:0] CMD_AUTOSEL = 8'h90;
    localparam logic [7:0] CMD_RESET   = 8'hF0;
    localparam logic [7:0] CMD_ADDR    = 8'h55;
    localparam logic [7:0] TAB_FIRST   = 8'h10;
    localparam logic [7:0] TAB_LAST    = 8'h26;

    typedef struct packed {
        logic       in_tab;
        logic       lane_ok;
        logic [7:0] off;
    } loc_t;

    function automatic logic [7:0] tab_entry(input logic [7:0] off);
        logic [7:0] v;
        case (off)
            8'h10: v = 8'h51;
            8'h11: v = 8'h52;
            8'h12: v = 8'h59;
            8'h13: v = 8'h02;
            8'h15: v = 8'h40;
            8'h1B: v = 8'h27;
            8'h1C: v = 8'h36;
            8'h1F: v = 8'h07;
            8'h20: v = 8'h07;
            8'h21: v = 8'h0A;
            8'h23: v = 8'h03;
            8'h24: v = 8'h05;
            8'h25: v = 8'h04;
            default: v = 8'h00;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/qry_addr_map.sv
module qry_addr_map #(
    parameter int ADDR_W = 8
) (
    input  logic              byte_mode,
    input  logic [ADDR_W-1:0] addr,
    output logic [ADDR_W-1:0] waddr,
    output qry_pkg::loc_t     loc
);
    import qry_pkg::*;

    always_comb begin
        if (byte_mode) waddr = {1'b0, addr[ADDR_W-1:1]};
        else           waddr = addr;
        loc.lane_ok = !(byte_mode && addr[0]);
        loc.in_tab  = (waddr >= ADDR_W'(TAB_FIRST)) && (waddr <= ADDR_W'(TAB_LAST));
        loc.off     = waddr[7:0];
    end

endmodule

// File: rtl/qry_cmd_fsm.sv
module qry_cmd_fsm #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              ready,
    input  logic [7:0]        cmd,
    input  logic [ADDR_W-1:0] waddr,
    output qry_pkg::mode_e    mode
);
    import qry_pkg::*;

    mode_e mode_n;
    logic  at_cmd;

    assign at_cmd = (waddr == ADDR_W'(CMD_ADDR));

    always_comb begin
        mode_n = mode;
        if (wr_en) begin
            if (cmd == CMD_RESET) begin
                mode_n = MD_ARRAY;
            end else if (at_cmd && ready) begin
                if (cmd == CMD_QUERY && mode != MD_QUERY)
                    mode_n = MD_QUERY;
                else if (cmd == CMD_AUTOSEL && mode == MD_ARRAY)
                    mode_n = MD_AUTOSEL;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) mode <= MD_ARRAY;
        else     mode <= mode_n;
    end

endmodule

// File: rtl/qry_rd_mux.sv
module qry_rd_mux #(
    parameter int          DATA_W   = 16,
    parameter logic [7:0]  MFR_CODE = 8'h01
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  qry_pkg::mode_e    mode,
    input  qry_pkg::loc_t     loc,
    input  logic              at_zero,
    input  logic [DATA_W-1:0] array_data,
    output logic [DATA_W-1:0] rdata
);
    import qry_pkg::*;

    localparam int PAD_W = DATA_W - 8;

    logic [DATA_W-1:0] rd_n;

    always_comb begin
        rd_n = '0;
        unique case (mode)
            MD_QUERY:
                if (loc.in_tab && loc.lane_ok)
                    rd_n = {{PAD_W{1'b0}}, tab_entry(loc.off)};
            MD_AUTOSEL:
                if (at_zero && loc.lane_ok)
                    rd_n = {{PAD_W{1'b0}}, MFR_CODE};
            default:
                rd_n = array_data;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)        rdata <= '0;
        else if (rd_en) rdata <= rd_n;
    end

endmodule

// File: rtl/qry_resp.sv
module qry_resp #(
    parameter int         ADDR_W   = 8,
    parameter int         DATA_W   = 16,
    parameter logic [7:0] MFR_CODE = 8'h01
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic              byte_mode,
    input  logic              ready,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] array_data,
    output logic [DATA_W-1:0] rdata
);
    import qry_pkg::*;

    logic [ADDR_W-1:0] waddr;
    loc_t              loc;
    mode_e             mode;
    logic              at_zero;

    assign at_zero = (waddr == '0);

    qry_addr_map #(.ADDR_W(ADDR_W)) u_map (
        .byte_mode (byte_mode),
        .addr      (addr),
        .waddr     (waddr),
        .loc       (loc)
    );

    qry_cmd_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk   (clk),
        .rst   (rst),
        .wr_en (wr_en),
        .ready (ready),
        .cmd   (wdata[7:0]),
        .waddr (waddr),
        .mode  (mode)
    );

    qry_rd_mux #(.DATA_W(DATA_W), .MFR_CODE(MFR_CODE)) u_mux (
        .clk        (clk),
        .rst        (rst),
        .rd_en      (rd_en),
        .mode       (mode),
        .loc        (loc),
        .at_zero    (at_zero),
        .array_data (array_data),
        .rdata      (rdata)
    );

endmodule

// File: rtl/qry_resp_chk.sv
module qry_resp_chk #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic              rd_en,
    input logic              ready,
    input logic [DATA_W-1:0] wdata,
    input logic [ADDR_W-1:0] waddr,
    input qry_pkg::mode_e    mode,
    input logic [DATA_W-1:0] rdata
);
    import qry_pkg::*;

    a_r1_reset_array: assert property (@(posedge clk)
        rst |=> (mode == MD_ARRAY && rdata == '0));

    a_r2_enter_query: assert property (@(posedge clk) disable iff (rst)
        (mode == MD_ARRAY && wr_en && ready && waddr == ADDR_W'(CMD_ADDR)
         && wdata[7:0] == CMD_QUERY) |=> mode == MD_QUERY);

    a_r3_busy_ignored: assert property (@(posedge clk) disable iff (rst)
        (mode == MD_ARRAY && wr_en && !ready && wdata[7:0] == CMD_QUERY)
        |=> mode == MD_ARRAY);

    a_r6_reset_cmd: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wdata[7:0] == CMD_RESET) |=> mode == MD_ARRAY);

    a_r7_upper_zero: assert property (@(posedge clk) disable iff (rst)
        (rd_en && mode == MD_QUERY) |=> rdata[DATA_W-1:8] == '0);

    a_r12_hold: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rdata));

    a_r13_stay_query: assert property (@(posedge clk) disable iff (rst)
        (mode == MD_QUERY && wr_en && wdata[7:0] != CMD_RESET)
        |=> mode == MD_QUERY);

endmodule

bind qry_resp qry_resp_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk   (clk),
    .rst   (rst),
    .wr_en (wr_en),
    .rd_en (rd_en),
    .ready (ready),
    .wdata (wdata),
    .waddr (waddr),
    .mode  (mode),
    .rdata (rdata)
);

// File: tb/sim_qry_resp.sv
module sim_qry_resp;
    timeunit 1ns;
    timeprecision 1ps;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic        byte_mode = 1'b0;
    logic        ready = 1'b1;
    logic [7:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] array_data = 16'hA5C3;
    logic [15:0] rdata;

    int errors = 0;
    int checks = 0;
    logic rd_seen = 1'b0;
    logic [15:0] exp_q[$];
    string       tag_q[$];

    always #2 clk = ~clk;

    qry_resp u0 (
        .clk (clk), .rst (rst), .wr_en (wr_en), .rd_en (rd_en),
        .byte_mode (byte_mode), .ready (ready), .addr (addr),
        .wdata (wdata), .array_data (array_data), .rdata (rdata)
    );

    task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    // monitor: a read sampled at a rising edge is compared at the next falling edge
    always @(posedge clk) rd_seen <= rd_en;
    always @(negedge clk) begin
        if (rd_seen) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL scoreboard: got %h expected nothing", rdata);
            end else begin
                check(rdata, exp_q.pop_front(), tag_q.pop_front());
            end
        end
    end

    task automatic rd(input logic [7:0] a, input logic [15:0] e, input string tag);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic summary;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #800000;
        checks++; errors++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end

    initial begin
        logic [7:0] tab [0:22];
        tab = '{8'h51, 8'h52, 8'h59, 8'h02, 8'h00, 8'h40, 8'h00, 8'h00,
                8'h00, 8'h00, 8'h00, 8'h27, 8'h36, 8'h00, 8'h00, 8'h07,
                8'h07, 8'h0A, 8'h00, 8'h03, 8'h05, 8'h04, 8'h00};
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check(rdata, 16'h0000, "R1 reset rdata");
        rd(8'h10, 16'hA5C3, "R1 array read");

        ready = 1'b0; wr(8'h55, 16'h0098); ready = 1'b1;
        rd(8'h10, 16'hA5C3, "R3 busy command ignored");

        wr(8'h55, 16'h0098);
        for (int i = 0; i < 23; i++) begin
            string t;
            if (i < 3)       t = $sformatf("R7 offset %h", 8'h10 + i);
            else if (i < 11) t = $sformatf("R8 offset %h", 8'h10 + i);
            else             t = $sformatf("R9 offset %h", 8'h10 + i);
            rd(8'h10 + 8'(i), {8'h00, tab[i]}, t);
        end
        rd(8'h0F, 16'h0000, "R11 below table");
        rd(8'h27, 16'h0000, "R11 above table");
        rd(8'h00, 16'h0000, "R11 offset zero");
        rd(8'h10, 16'h0051, "R6 query persists");
        wr(8'h10, 16'h00AB);
        rd(8'h11, 16'h0052, "R13 other write keeps query");

        byte_mode = 1'b1;
        rd(8'h20, 16'h0051, "R10 byte 20h");
        rd(8'h21, 16'h0000, "R10 odd byte");
        rd(8'h24, 16'h0059, "R10 byte 24h");
        rd(8'h42, 16'h000A, "R10 byte 42h");
        rd(8'h4A, 16'h0004, "R10 byte 4Ah");
        rd(8'h4E, 16'h0000, "R11 byte above table");
        wr(8'h00, 16'h00F0);
        rd(8'h20, 16'hA5C3, "R6 reset command byte mode");
        byte_mode = 1'b0;

        wr(8'h55, 16'h0090);
        rd(8'h00, 16'h0001, "R4 manufacturer code");
        rd(8'h01, 16'h0000, "R4 other offset");
        rd(8'h10, 16'h0000, "R4 table offset in autoselect");
        wr(8'h55, 16'h0098);
        rd(8'h12, 16'h0059, "R5 autoselect to query");
        wr(8'h00, 16'h00F0);
        rd(8'h12, 16'hA5C3, "R6 back to array");

        byte_mode = 1'b1;
        wr(8'hAA, 16'h0098);
        rd(8'h22, 16'h0052, "R10 byte-mode command");
        wr(8'h00, 16'h00F0);
        byte_mode = 1'b0;

        rd(8'h00, 16'hA5C3, "R12 read before hold");
        array_data = 16'h1234;
        @(negedge clk);
        check(rdata, 16'hA5C3, "R12 hold without read");
        rd(8'h00, 16'h1234, "R12 new read");

        repeat (2) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL scoreboard: got %0d pending expected 0", exp_q.size());
        end
        summary();
    end
endmodule